// File: doc/BRIEF.md
# Pipelined Unsigned Integer to Single-Precision Float Converter

This block turns a stream of 16-bit unsigned integers into IEEE-754 single-precision values. It takes at most one sample per clock and has no stall path, so a producer that asserts `in_valid` on every cycle keeps all six stages busy. Each result leaves the block a fixed number of cycles after its input, in the order the inputs arrived. A valid flag travels with the sample through the pipeline.

The block converts with the "magic number" method. The integer is ORed into the low fraction bits of the float whose value is 2^23. Both operands of the next step then have the same exponent, so subtracting 2^23 as a float is an exact fraction subtraction. Its result is the integer again, held as an unnormalised significand. A leading-one search and a left shift normalise it, and the last stage packs sign, exponent and fraction. Every stage holds its own registers, so a new sample never overwrites one still in flight. The stages fill one per cycle after start-up and empty one per cycle after the last input.

Top module: `u16_to_f32_pipe`

## Requirements
- R1: Reset is synchronous and active high. After any rising edge that samples `rst` high, `out_valid` is low, and every sample in flight at that edge is discarded and never appears at the output.
- R2: A sample captured with `in_valid` high at a rising edge appears, with `out_valid` high, in the output register written by the sixth rising edge counting the capturing edge as the first.
- R3: An input of zero gives the result 0x00000000 (positive zero).
- R4: A nonzero input whose highest set bit is at position p gives a result with bit 31 = 0, bits 30:23 = 127 + p, and bits 22:0 holding the input bits below position p, left-aligned so the bit just below p lands on bit 22, with all lower fraction bits zero. The conversion is exact.
- R5: Samples offered on consecutive cycles are all accepted. Their results appear on consecutive cycles in the same order.
- R6: A cycle with `in_valid` low creates a bubble. The matching output cycle has `out_valid` low, `in_data` is ignored in that cycle, and the results of the neighbouring samples are unchanged.
- R7: At the range boundaries, input 1 gives 0x3F800000, input 0x8000 gives 0x47000000 and input 0xFFFF gives 0x477FFF00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_data` as a sample to convert this cycle |
| in_data | input | 16 | Unsigned integer sample |
| out_valid | output | 1 | Marks `out_result` as a converted sample |
| out_result | output | 32 | Single-precision result: sign 31, exponent 30:23, fraction 22:0 |

## Verification
The hardest cases to reach from the ports are a reset that lands while several samples are still in the pipe, and a bubble whose `in_data` carries garbage next to valid samples. Either one would show a valid flag or a data word that slipped a stage. The stimulus fills the pipe, then raises reset with samples in stages one to three and watches that none of them comes out. It also runs alternating valid and invalid cycles with changing junk data and checks every output slot against a record of what was offered at each edge. Walking single bits and a long pseudo-random back-to-back run cover every leading-one position.

// File: rtl/u2f_pkg.sv
package u2f_pkg;
    localparam int F_EXP_W = 8;
    localparam int F_MAN_W = 23;
    localparam int F_BIAS  = 127;
    localparam int SIG_W   = F_MAN_W + 1;

    typedef struct packed {
        logic               sign;
        logic [F_EXP_W-1:0] exp;
        logic [F_MAN_W-1:0] frac;
    } f32_t;

    // Float whose value is 2^23: the unit of its fraction field is exactly 1.
    localparam f32_t MAGIC = '{sign: 1'b0, exp: 8'(F_BIAS + F_MAN_W), frac: '0};

    function automatic logic [SIG_W-1:0] sig_of(input f32_t f);
        return {1'b1, f.frac};
    endfunction
endpackage

// File: rtl/u2f_magic_sub.sv
module u2f_magic_sub
    import u2f_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               chk_en,
    input  f32_t               minuend,
    output logic [SIG_W-1:0]   diff,
    output logic [F_EXP_W-1:0] exp_o
);
    // Float subtraction minuend - MAGIC. The operands share one exponent,
    // so no alignment shift is needed and the fraction difference is exact.
    assign diff  = sig_of(minuend) - sig_of(MAGIC);
    assign exp_o = minuend.exp;

    // R4: the pattern entering the subtractor must line up with the constant
    // and leave a difference that fits in the low fraction bits.
    // R4
    magic_align_chk: assert property (@(posedge clk) disable iff (rst)
        chk_en |-> (minuend.exp == MAGIC.exp && minuend.sign == MAGIC.sign
                    && diff[SIG_W-1] == 1'b0));
endmodule

// File: rtl/u2f_lead_one.sv
module u2f_lead_one #(
    parameter  int W  = 16,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] pos,
    output logic          none
);
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = PW'(i);
        end
    end
    assign none = ~|vec;
endmodule

// File: rtl/u2f_norm.sv
module u2f_norm
    import u2f_pkg::*;
#(
    parameter  int W  = 16,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]       sig,
    input  logic [PW-1:0]      pos,
    input  logic [F_EXP_W-1:0] exp_in,
    output logic [SIG_W-1:0]   man,
    output logic [F_EXP_W-1:0] exp_o
);
    localparam logic [4:0] TOP = 5'(F_MAN_W);

    // Move the leading one up to the hidden-bit position and rebase the
    // exponent: value = sig * 2^(exp_in - bias - F_MAN_W).
    assign man   = SIG_W'(sig) << (TOP - 5'(pos));
    assign exp_o = exp_in - F_EXP_W'(F_MAN_W) + F_EXP_W'(pos);
endmodule

// File: rtl/u16_to_f32_pipe.sv
module u16_to_f32_pipe
    import u2f_pkg::*;
#(
    // Integer width; must stay at or below F_MAN_W for exact conversion.
    parameter  int IN_W = 16,
    localparam int PW   = $clog2(IN_W)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_data,
    output logic            out_valid,
    output logic [31:0]     out_result
);
    // Stage 1: capture
    logic s1_v;  logic [IN_W-1:0] s1_d;
    // Stage 2: OR into magic pattern
    logic s2_v;  f32_t s2_w;
    // Stage 3: float subtract of 2^23
    logic s3_v;  logic [IN_W-1:0] s3_sig;  logic [F_EXP_W-1:0] s3_exp;
    // Stage 4: leading-one search
    logic s4_v;  logic [IN_W-1:0] s4_sig;  logic [F_EXP_W-1:0] s4_exp;
    logic [PW-1:0] s4_pos;  logic s4_zero;
    // Stage 5: normalise
    logic s5_v;  logic [SIG_W-1:0] s5_man;  logic [F_EXP_W-1:0] s5_exp;  logic s5_zero;
    // Stage 6: pack
    logic s6_v;  f32_t s6_res;

    logic [SIG_W-1:0]   sub_diff;
    logic [F_EXP_W-1:0] sub_exp;
    logic [PW-1:0]      lo_pos;
    logic               lo_none;
    logic [SIG_W-1:0]   nm_man;
    logic [F_EXP_W-1:0] nm_exp;

    u2f_magic_sub u_sub (
        .clk(clk), .rst(rst), .chk_en(s2_v),
        .minuend(s2_w), .diff(sub_diff), .exp_o(sub_exp)
    );

    u2f_lead_one #(.W(IN_W)) u_lead (
        .vec(s3_sig), .pos(lo_pos), .none(lo_none)
    );

    u2f_norm #(.W(IN_W)) u_norm (
        .sig(s4_sig), .pos(s4_pos), .exp_in(s4_exp),
        .man(nm_man), .exp_o(nm_exp)
    );

    // Valid chain: the only state that reset touches.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0; s2_v <= 1'b0; s3_v <= 1'b0;
            s4_v <= 1'b0; s5_v <= 1'b0; s6_v <= 1'b0;
        end else begin
            s1_v <= in_valid; s2_v <= s1_v; s3_v <= s2_v;
            s4_v <= s3_v;     s5_v <= s4_v; s6_v <= s5_v;
        end
    end

    // Data registers: one set per stage, written every cycle.
    always_ff @(posedge clk) begin
        s1_d    <= in_data;
        s2_w    <= f32_t'(MAGIC | 32'(s1_d));
        s3_sig  <= sub_diff[IN_W-1:0];
        s3_exp  <= sub_exp;
        s4_sig  <= s3_sig;
        s4_exp  <= s3_exp;
        s4_pos  <= lo_pos;
        s4_zero <= lo_none;
        s5_man  <= nm_man;
        s5_exp  <= nm_exp;
        s5_zero <= s4_zero;
        s6_res  <= s5_zero ? '0 : '{sign: 1'b0, exp: s5_exp, frac: s5_man[F_MAN_W-1:0]};
    end

    assign out_valid  = s6_v;
    assign out_result = s6_res;

    // ---------------- checks ----------------
    logic [2:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    logic [SIG_W-1:0]   chk_sig;
    logic [F_EXP_W-1:0] chk_sh;
    logic [SIG_W-1:0]   chk_int;
    assign chk_sig = {1'b1, s6_res.frac};
    assign chk_sh  = 8'(F_BIAS + F_MAN_W) - s6_res.exp;
    assign chk_int = chk_sig >> chk_sh;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd6) |-> (out_valid == $past(in_valid, 6)));

    // R3
    zero_result_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd6 && out_valid && $past(in_data, 6) == '0) |-> (out_result == 32'h0));

    // R4
    exact_value_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd6 && out_valid && out_result != 32'h0) |->
            (s6_res.sign == 1'b0 && s6_res.exp >= 8'(F_BIAS)
             && s6_res.exp < 8'(F_BIAS + IN_W)
             && (chk_int << chk_sh) == chk_sig
             && chk_int == SIG_W'($past(in_data, 6))));

    // R4
    hidden_bit_chk: assert property (@(posedge clk) disable iff (rst)
        s5_v |-> (s5_man[SIG_W-1] == !s5_zero));
endmodule

// File: tb/u16_to_f32_pipe_tb.sv
module u16_to_f32_pipe_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_tag = "R1";

    logic        rv [8];
    logic [31:0] rd [8];
    string       rt [8];

    always #5 clk = ~clk;

    u16_to_f32_pipe u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [31:0] ref_f32(input logic [15:0] x);
        int p;
        if (x == 16'h0) return 32'h0;
        p = 0;
        for (int i = 0; i < 16; i++) if (x[i]) p = i;
        return {1'b0, 8'(127 + p), 23'(32'(x) << (23 - p))};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Record what was offered at every edge; a reset edge voids everything in flight.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) rv[i] = 1'b0;
        end
        rv[(cyc + 1) % 8] = in_valid && !rst;
        rd[(cyc + 1) % 8] = ref_f32(in_data);
        rt[(cyc + 1) % 8] = cur_tag;
        cyc <= cyc + 1;
    end

    // Output written by edge e+5 holds the sample captured at edge e.
    always @(negedge clk) begin
        if (cyc >= 5) begin
            if (rv[(cyc - 5) % 8]) begin
                chk(out_valid == 1'b1, {rt[(cyc - 5) % 8], " R2 valid"}, 32'(out_valid), 32'h1);
                chk(out_result == rd[(cyc - 5) % 8], {rt[(cyc - 5) % 8], " R4 value"},
                    out_result, rd[(cyc - 5) % 8]);
            end else begin
                chk(out_valid == 1'b0, {rt[(cyc - 5) % 8], " bubble"}, 32'(out_valid), 32'h0);
            end
        end
    end

    task automatic drive(input logic v, input logic [15:0] d);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 16'hDEAD);
    endtask

    // R1: state under reset
    task automatic t_reset;
        cur_tag = "R1";
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'h0);
        rst = 1'b0;
    endtask

    // R2: count cycles for one isolated sample
    task automatic t_latency;
        int seen;
        cur_tag = "R2";
        seen = 0;
        drive(1'b1, 16'h00A5);
        for (int k = 1; k <= 9; k++) begin
            drive(1'b0, 16'h0);
            if (out_valid && seen == 0) seen = k;
        end
        chk(seen == 6, "R2 latency in cycles", 32'(seen), 32'd6);
    endtask

    task automatic single(input logic [15:0] d, input logic [31:0] exp, input string tag);
        cur_tag = tag;
        drive(1'b1, d);
        drive(1'b0, 16'h0);
        repeat (5) @(negedge clk);
        chk(out_valid && out_result == exp, tag, out_result, exp);
    endtask

    // R3, R7: zero and range ends against fixed encodings
    task automatic t_corners;
        single(16'h0000, 32'h00000000, "R3 zero");
        single(16'h0001, 32'h3F800000, "R7 one");
        single(16'h8000, 32'h47000000, "R7 top bit");
        single(16'hFFFF, 32'h477FFF00, "R7 all ones");
        single(16'h0003, 32'h40400000, "R4 three");
    endtask

    // R4, R5: every leading-one position, back to back
    task automatic t_walk;
        cur_tag = "R4 walk";
        for (int i = 0; i < 16; i++) drive(1'b1, 16'(1 << i));
        for (int i = 0; i < 16; i++) drive(1'b1, 16'((1 << i) | 1));
        idle(8);
    endtask

    // R5: long pseudo-random burst, then drain
    task automatic t_stream;
        logic [15:0] lfsr;
        cur_tag = "R5 stream";
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            drive(1'b1, lfsr);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        drive(1'b1, 16'h0000);
        idle(8);
    endtask

    // R6: bubbles carrying junk between valid samples
    task automatic t_bubbles;
        cur_tag = "R6 bubbles";
        for (int i = 0; i < 40; i++) begin
            if (i % 3 == 1) drive(1'b0, 16'(16'hFFFF - i));
            else            drive(1'b1, 16'(i * 977 + 5));
        end
        idle(8);
    endtask

    // R1: reset with samples still in flight
    task automatic t_mid_reset;
        int leaked;
        cur_tag = "R1 mid reset";
        drive(1'b1, 16'h1234);
        drive(1'b1, 16'h4321);
        drive(1'b1, 16'h0F0F);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        leaked = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (out_valid) leaked++;
        end
        chk(leaked == 0, "R1 in-flight samples dropped", 32'(leaked), 32'h0);
    endtask

    initial begin
        t_reset();
        idle(2);
        t_latency();
        t_corners();
        t_walk();
        t_stream();
        t_bubbles();
        t_mid_reset();
        single(16'h7FFF, 32'h46FFFE00, "R4 after reset");
        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule